// File: doc/BRIEF.md
# Single-Byte I2C Master Controller

This block is a synchronous I2C master that carries out one complete single-byte bus transaction each time a one-cycle launch strobe arrives while it is idle. At the strobe it captures a 7-bit target address, a direction select and an 8-bit write byte. It then generates a START condition, sends the address byte, checks the target's acknowledge, and either transmits the write byte or receives a byte from the target. It ends every transaction with a STOP condition.

The serial clock is derived from the system clock, with four system clocks per SCL period. The data line is presented as three separate signals: a driven value, an output enable that marks when the master owns the line, and the sampled line level. The external pad logic can therefore form the open-drain line. A received byte appears on a parallel output register. One-cycle flags report the outcome: a completion flag when the transfer succeeds and an error flag when the target refuses an acknowledge.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is asserted (active low), `scl`, `sda_out`, `sda_oe`, `rd_byte`, `done` and `err` are all 0.
- R2: A `start_stb` pulse while idle begins a transaction whose START condition is `sda_out` falling while `scl` is high. A fully acknowledged transaction lasts 80 system clocks, measured from the strobe edge to the first cycle in which `done` is visible: 20 SCL periods of 4 clocks each.
- R3: The first byte on the bus holds the 7 address bits, most significant bit first, followed by the direction bit (1 = read, 0 = write).
- R4: On a write, once the address is acknowledged, the write byte captured at the strobe is sent most significant bit first.
- R5: On a read, the 8 data bits are sampled while SCL is high, most significant bit first, and the byte is loaded into `rd_byte`. In the following slot the master drives a NACK (`sda_oe`=1, `sda_out`=1). `rd_byte` is left unchanged by any transaction that does not complete a read.
- R6: `sda_oe` is 0 during the address acknowledge slot, the write-data acknowledge slot and all 8 read data bits. `sda_oe` changes only while `scl` is low.
- R7: A NACK (line high) in the address acknowledge slot skips the data phase, issues STOP and ends 44 clocks after the strobe. A NACK on the write data also ends in STOP. In both cases `err` pulses for exactly one cycle and `done` stays 0.
- R8: Every transaction ends with a STOP condition: `sda_out` rising while `scl` is high. After a successful transaction, `done` pulses for exactly one cycle and `err` stays 0.
- R9: A `start_stb` that arrives during a transaction is ignored. It does not change the address being sent, and it does not start a second transaction.
- R10: Each SCL period holds `scl` high for exactly two consecutive system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the chip |
| start_stb | input | 1 | One-cycle launch strobe |
| rd_nwr | input | 1 | Direction select captured at the strobe: 1 read, 0 write |
| tgt_addr | input | 7 | Target address captured at the strobe |
| wr_byte | input | 8 | Byte to transmit on a write, captured at the strobe |
| sda_in | input | 1 | Sampled level of the data line |
| scl | output | 1 | Serial clock |
| sda_out | output | 1 | Value driven onto the data line when enabled |
| sda_oe | output | 1 | Data line output enable, 1 while the master owns the line |
| rd_byte | output | 8 | Last byte received by a read |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on a refused acknowledge |

## Verification
A behavioural target on the bench decodes START and STOP from the pins, reassembles the address and write bytes, and answers with acknowledges or read data that change only on SCL falling edges. The table covers three acknowledge corner cases: a NACK on the address of a write, a NACK on the address of a read, and a NACK on the write data. A design that ignored the address NACK would run a data phase, take 80 clocks instead of 44 and pulse `done`. A design that corrupted `rd_byte` on an aborted read would lose the previous value. Directed tests raise a second strobe mid-transfer, where a design that re-latched its inputs would send a mangled address or a second START. They also pull reset mid-transfer, where a design that failed to clear its registers would leave the bus driven or keep a stale received byte.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_RDATA,
    ST_DACK,
    ST_STOP
  } bm_state_e;
endpackage

// File: rtl/i2c_bm_phase.sv
// Slot phase counter: one SCL period per slot.
module i2c_bm_phase #(
  parameter int unsigned SLOT_CLKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  output logic [$clog2(SLOT_CLKS)-1:0] ph,
  output logic                         slot_end,
  output logic                         samp
);
  localparam int unsigned PH_W = $clog2(SLOT_CLKS);
  localparam int unsigned Q1   = SLOT_CLKS / 4;

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    if (!run) begin
      ph_d = '0;
    end else if (ph_q == PH_W'(SLOT_CLKS - 1)) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign ph       = ph_q;
  assign slot_end = run && (ph_q == PH_W'(SLOT_CLKS - 1));
  assign samp     = run && (ph_q == PH_W'(Q1));
endmodule

// File: rtl/i2c_bm_txsr.sv
// Parallel-load, MSB-first transmit shifter.
module i2c_bm_txsr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         ser_out
);
  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  assign sr_en = load | shift;

  always_comb begin
    if (load) begin
      sr_d = load_val;
    end else begin
      sr_d = {sr_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign ser_out = sr_q[W-1];
endmodule

// File: rtl/i2c_bm_ctrl.sv
// Transaction sequencer and line encoder.
module i2c_bm_ctrl
  import i2c_bm_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SLOT_CLKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_stb,
  input  logic                         rd_nwr,
  input  logic [$clog2(SLOT_CLKS)-1:0] ph,
  input  logic                         slot_end,
  input  logic                         samp,
  input  logic                         sda_in,
  input  logic                         tx_bit,
  output logic                         run,
  output logic                         tx_load_addr,
  output logic                         tx_load_data,
  output logic                         tx_shift,
  output logic                         rx_shift,
  output logic                         rd_cap,
  output logic                         scl,
  output logic                         sda_out,
  output logic                         sda_oe,
  output logic                         done,
  output logic                         err
);
  localparam int unsigned PH_W  = $clog2(SLOT_CLKS);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam int unsigned Q1    = SLOT_CLKS / 4;
  localparam int unsigned Q3    = (3 * SLOT_CLKS) / 4;
  localparam int unsigned HALF  = SLOT_CLKS / 2;

  bm_state_e          st_q, st_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic               rw_q, rw_d;
  logic               fail_q, fail_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               last_bit;
  logic               mid;

  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));
  assign mid      = (ph >= PH_W'(Q1)) && (ph < PH_W'(Q3));
  assign run      = (st_q != ST_IDLE);

  // next-state process
  always_comb begin
    st_d         = st_q;
    bit_d        = bit_q;
    rw_d         = rw_q;
    fail_d       = fail_q;
    done_d       = 1'b0;
    err_d        = 1'b0;
    tx_load_addr = 1'b0;
    tx_load_data = 1'b0;
    tx_shift     = 1'b0;
    rx_shift     = 1'b0;
    rd_cap       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_stb) begin
          st_d         = ST_START;
          rw_d         = rd_nwr;
          fail_d       = 1'b0;
          tx_load_addr = 1'b1;
        end
      end
      ST_START: begin
        if (slot_end) begin
          st_d  = ST_ADDR;
          bit_d = '0;
        end
      end
      ST_ADDR, ST_WDATA: begin
        if (slot_end) begin
          tx_shift = 1'b1;
          if (last_bit) begin
            st_d = (st_q == ST_ADDR) ? ST_AACK : ST_DACK;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_AACK: begin
        if (samp) begin
          fail_d = sda_in;
        end
        if (slot_end) begin
          bit_d = '0;
          if (fail_q) begin
            st_d = ST_STOP;
          end else if (rw_q) begin
            st_d = ST_RDATA;
          end else begin
            st_d         = ST_WDATA;
            tx_load_data = 1'b1;
          end
        end
      end
      ST_RDATA: begin
        rx_shift = samp;
        if (slot_end) begin
          if (last_bit) begin
            rd_cap = 1'b1;
            st_d   = ST_DACK;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_DACK: begin
        if (samp && !rw_q) begin
          fail_d = sda_in;
        end
        if (slot_end) begin
          st_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (slot_end) begin
          st_d   = ST_IDLE;
          done_d = !fail_q;
          err_d  = fail_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rw_q   <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      rw_q   <= rw_d;
      fail_q <= fail_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // line encoder: data moves only at slot boundaries, where SCL is low
  always_comb begin
    scl     = run && mid;
    sda_out = 1'b0;
    sda_oe  = 1'b0;
    unique case (st_q)
      ST_START: begin
        sda_out = (ph < PH_W'(HALF));
        sda_oe  = 1'b1;
      end
      ST_ADDR, ST_WDATA: begin
        sda_out = tx_bit;
        sda_oe  = 1'b1;
      end
      ST_DACK: begin
        sda_out = rw_q;
        sda_oe  = rw_q;
      end
      ST_STOP: begin
        sda_out = (ph >= PH_W'(HALF));
        sda_oe  = 1'b1;
      end
      default: begin
        sda_out = 1'b0;
        sda_oe  = 1'b0;
      end
    endcase
  end

  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SLOT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic              rd_nwr,
  input  logic [DATA_W-2:0] tgt_addr,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              sda_in,
  output logic              scl,
  output logic              sda_out,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rd_byte,
  output logic              done,
  output logic              err
);
  localparam int unsigned PH_W = $clog2(SLOT_CLKS);

  logic [PH_W-1:0]   ph;
  logic              slot_end, samp, run;
  logic              tx_load_addr, tx_load_data, tx_shift, tx_bit;
  logic              rx_shift, rd_cap;
  logic [DATA_W-1:0] wdata_q, rx_q, rd_q, tx_val;

  i2c_bm_phase #(.SLOT_CLKS(SLOT_CLKS)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ph       (ph),
    .slot_end (slot_end),
    .samp     (samp)
  );

  assign tx_val = tx_load_addr ? {tgt_addr, rd_nwr} : wdata_q;

  i2c_bm_txsr #(.W(DATA_W)) u_txsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load_addr | tx_load_data),
    .load_val (tx_val),
    .shift    (tx_shift),
    .ser_out  (tx_bit)
  );

  i2c_bm_ctrl #(.DATA_W(DATA_W), .SLOT_CLKS(SLOT_CLKS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_stb    (start_stb),
    .rd_nwr       (rd_nwr),
    .ph           (ph),
    .slot_end     (slot_end),
    .samp         (samp),
    .sda_in       (sda_in),
    .tx_bit       (tx_bit),
    .run          (run),
    .tx_load_addr (tx_load_addr),
    .tx_load_data (tx_load_data),
    .tx_shift     (tx_shift),
    .rx_shift     (rx_shift),
    .rd_cap       (rd_cap),
    .scl          (scl),
    .sda_out      (sda_out),
    .sda_oe       (sda_oe),
    .done         (done),
    .err          (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (tx_load_addr) begin
      wdata_q <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_shift) begin
      rx_q <= {rx_q[DATA_W-2:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_cap) begin
      rd_q <= rx_q;
    end
  end

  assign rd_byte = rd_q;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda_oe,
  input logic done,
  input logic err
);
  AST_SCL_HIGH_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl) |=> scl);                                   // R10
  AST_SCL_HIGH_NOT_THRICE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl)) |=> !scl);                         // R10
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);                               // R6
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl);                               // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                       // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);                                         // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));                                       // R7
  AST_END_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!scl && !sda_oe));                  // R8
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl    (scl),
  .sda_oe (sda_oe),
  .done   (done),
  .err    (err)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_stb = 1'b0;
  logic       rd_nwr = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic [7:0] wr_byte = '0;
  logic       sda_in = 1'b1;
  logic       scl, sda_out, sda_oe, done, err;
  logic [7:0] rd_byte;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  i2c_byte_master dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_stb (start_stb),
    .rd_nwr    (rd_nwr),
    .tgt_addr  (tgt_addr),
    .wr_byte   (wr_byte),
    .sda_in    (sda_in),
    .scl       (scl),
    .sda_out   (sda_out),
    .sda_oe    (sda_oe),
    .rd_byte   (rd_byte),
    .done      (done),
    .err       (err)
  );

  // vector: addr[25:19] rw[18] wdata[17:10] target_byte[9:2] addr_ack[1] data_ack[0]
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {7'h50, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b1},
    {7'h2B, 1'b1, 8'h00, 8'h3C, 1'b1, 1'b1},
    {7'h7F, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},
    {7'h01, 1'b1, 8'hFF, 8'h81, 1'b1, 1'b0},
    {7'h33, 1'b0, 8'h5A, 8'h00, 1'b0, 1'b1},
    {7'h44, 1'b0, 8'hC3, 8'h00, 1'b1, 1'b0},
    {7'h12, 1'b1, 8'h00, 8'h96, 1'b0, 1'b1}
  };

  // behavioural target
  logic [6:0] cur_addr;
  logic       cur_rw, cur_aack, cur_dack;
  logic [7:0] cur_wd, cur_slv;
  logic [7:0] a_cap, d_cap;
  int         bitn = 0;
  int         starts = 0;
  int         stops = 0;
  bit         oe_bad, mnack_ok;

  always @(negedge sda_out) if (scl && sda_oe) begin starts++; bitn = 0; end
  always @(posedge sda_out) if (scl && sda_oe) stops++;

  always @(posedge scl) begin
    bitn++;
    if (bitn >= 1 && bitn <= 8) a_cap = {a_cap[6:0], sda_out};
    if (bitn == 9 && sda_oe) oe_bad = 1'b1;
    if (cur_aack && !cur_rw && bitn >= 10 && bitn <= 17) d_cap = {d_cap[6:0], sda_out};
    if (cur_aack && !cur_rw && bitn == 18 && sda_oe) oe_bad = 1'b1;
    if (cur_aack && cur_rw && bitn >= 10 && bitn <= 17 && sda_oe) oe_bad = 1'b1;
    if (cur_aack && cur_rw && bitn == 18 && sda_oe && sda_out) mnack_ok = 1'b1;
  end

  always @(negedge scl) begin
    if (bitn == 8) sda_in = !cur_aack;
    else if (cur_aack && cur_rw && bitn >= 9 && bitn <= 16) sda_in = cur_slv[16-bitn];
    else if (cur_aack && !cur_rw && bitn == 17) sda_in = !cur_dack;
    else sda_in = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [25:0] v, input int busy_at);
    int n;
    int st0, sp0;
    logic [7:0] rd_before;
    bit exp_err;
    bit got_done, got_err;
    {cur_addr, cur_rw, cur_wd, cur_slv, cur_aack, cur_dack} = v;
    a_cap = '0; d_cap = '0; oe_bad = 1'b0; mnack_ok = 1'b0;
    st0 = starts; sp0 = stops; rd_before = rd_byte;
    exp_err = !cur_aack || (!cur_rw && !cur_dack);
    @(negedge clk);
    tgt_addr = cur_addr; rd_nwr = cur_rw; wr_byte = cur_wd; start_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
    n = 0;
    while (!(done || err) && n < 400) begin
      @(negedge clk);
      n++;
      if (n == busy_at) begin
        start_stb = 1'b1; tgt_addr = ~cur_addr; rd_nwr = ~cur_rw;
      end else begin
        start_stb = 1'b0;
      end
    end
    start_stb = 1'b0;
    got_done = done; got_err = err;
    chk(starts - st0 == 1, "R2 one START", starts - st0, 1);
    chk(n == (cur_aack ? 80 : 44), cur_aack ? "R2 length" : "R7 short length", n, cur_aack ? 80 : 44);
    chk(a_cap == {cur_addr, cur_rw}, busy_at > 0 ? "R9 address kept" : "R3 address byte",
        a_cap, {cur_addr, cur_rw});
    if (cur_aack && !cur_rw) chk(d_cap == cur_wd, "R4 write byte", d_cap, cur_wd);
    if (cur_aack && cur_rw) begin
      chk(rd_byte == cur_slv, "R5 read byte", rd_byte, cur_slv);
      chk(mnack_ok, "R5 master NACK", mnack_ok, 1);
    end else begin
      chk(rd_byte == rd_before, "R5 rd_byte kept", rd_byte, rd_before);
    end
    chk(!oe_bad, "R6 oe released", oe_bad, 0);
    chk(stops - sp0 == 1, "R8 STOP", stops - sp0, 1);
    chk(got_err == exp_err, "R7 err flag", got_err, exp_err);
    chk(got_done == !exp_err, "R8 done flag", got_done, !exp_err);
    @(negedge clk);
    chk(!done && !err, "R8 R7 flag width", {done, err}, 0);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    cur_addr = '0; cur_rw = 1'b0; cur_aack = 1'b1; cur_dack = 1'b1; cur_wd = '0; cur_slv = '0;
    a_cap = '0; d_cap = '0; oe_bad = 1'b0; mnack_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk({scl, sda_out, sda_oe, done, err} == 5'b0 && rd_byte == 8'h00, "R1 reset outputs",
        {scl, sda_out, sda_oe, done, err, rd_byte}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl && !sda_oe, "R1 idle after release", {scl, sda_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i], 0);
      repeat (5) @(negedge clk);
    end

    // R9: strobe inside a transaction
    begin
      int st1;
      run_txn({7'h5C, 1'b0, 8'h69, 8'h00, 1'b1, 1'b1}, 20);
      st1 = starts;
      repeat (100) @(negedge clk);
      chk(starts == st1 && !scl && !sda_oe, "R9 no second START", starts - st1, 0);
    end

    // R1: reset in the middle of a write, after rd_byte holds 0x81
    @(negedge clk);
    tgt_addr = 7'h22; rd_nwr = 1'b0; wr_byte = 8'hF0; start_stb = 1'b1;
    cur_addr = 7'h22; cur_rw = 1'b0; cur_aack = 1'b1; cur_dack = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
    repeat (30) @(negedge clk);
    chk(rd_byte == 8'h81, "R5 rd_byte before reset", rd_byte, 8'h81);
    rst_n = 1'b0;
    #1;
    chk({scl, sda_out, sda_oe, done, err} == 5'b0 && rd_byte == 8'h00, "R1 mid-transfer reset",
        {scl, sda_out, sda_oe, done, err, rd_byte}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(VEC[1], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule